// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins controlled through a simple synchronous register port. Each pin has four 32-bit registers in its own 16-byte window. A pad configuration register stores the pull, function, drive and output-enable fields. A data register returns the synchronized input level and holds the value to drive. An interrupt configuration register selects the trigger type and its gating. A status register holds a sticky trigger flag.

Each input goes through a two-flop synchronizer and one further history flop. A trigger can be a level of either polarity, a rising edge, a falling edge or any edge. A trigger can set the pin's sticky status flag, and it separately sets a pending flag that drives the interrupt. Two independent enables gate these two paths. The bank ORs the interrupts of every pin that is enabled, targets the application processor (code 4) and is not in direct-connect mode. The result is one request line, `irq_out`.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin p's registers sit at byte address 16*p + 4*k. k=0 is pad configuration: pull [1:0], function [5:2], drive [8:6], output enable [9]. k=1 is data. k=2 is interrupt configuration. k=3 is status. Address bits [1:0] are ignored. Configuration reads back its 10 stored bits and interrupt configuration its 9 stored bits. All other bits read as zero.
- R2: `pin_oe[p]` equals configuration bit 9. `pin_out[p]` equals data bit 1 while bit 9 is set, and is 0 otherwise. Both follow a write in the next cycle.
- R3: Data register bit 0 reads the pin input after a two-flop synchronizer. Bit 1 reads back the stored output value.
- R4: Interrupt configuration bits [3:2] select the detect mode. 0 is level, 1 is rising edge, 2 is falling edge and 3 is either edge. An edge is found by comparing the synchronized level with its value one cycle earlier.
- R5: In level mode, bit 1 sets the polarity. With bit 1 = 1 a high pin triggers, and with bit 1 = 0 a low pin triggers.
- R6: Bit 4 (status enable) gates only the status flag. With bit 4 clear, a trigger leaves status at 0 but can still raise `irq_out`.
- R7: Bit 0 (interrupt enable) gates only the interrupt. With bit 0 clear, status is still set. Setting bit 0 later raises `irq_out` for a trigger that is still pending.
- R8: Only target code 4 in bits [7:5] lets the pin reach `irq_out`. Code 7 (no target) blocks it, but status is still set.
- R9: With bit 8 (direct connect) set, the pin is left out of `irq_out` and its triggers set neither status nor pending.
- R10: Writing zero to the status register clears the pin's status and pending flags. Writing a nonzero value has no effect. A trigger in the same cycle as a clear wins.
- R11: Read data is registered. It appears on `bus_rdata` in the cycle after the read request and holds until the next read. Status reads return the flag in bit 0.
- R12: After reset, all registers read zero and `pin_oe`, `pin_out` and `irq_out` are low.
- R13: Pins are independent. A trigger on one pin sets no other pin's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address: pin index above bit 4, register in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS (4) | Asynchronous pin inputs |
| pin_out | output | NUM_PINS (4) | Output value, forced to 0 when not enabled |
| pin_oe | output | NUM_PINS (4) | Output enable per pin |
| irq_out | output | 1 | Combined interrupt request to the application processor |

## Verification
A register write takes effect at the clock edge that accepts it, so `pin_oe`, `pin_out` and `irq_out` are sampled at the following falling edge. A read returns its data one cycle after the request, and the bench samples `bus_rdata` at the falling edge after that capturing edge. A change on `pin_in` reaches the status and pending flags at the third rising edge. The bench therefore waits four cycles after every pin change before it reads status or samples `irq_out`. Before each table vector, direct connect is turned on to block triggers, the pin is parked and the status is cleared. This leaves no stale edge in the history flop when the tested mode is enabled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_W = 32;
  localparam int PCFG_W = 10;
  localparam int ICFG_W = 9;

  typedef enum logic [1:0] {
    RSEL_PAD  = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_ICFG = 2'd2,
    RSEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_ANY   = 2'd3
  } det_mode_e;

  localparam logic [2:0] TGT_APPS = 3'd4;

  // bit 9 down to bit 0
  typedef struct packed {
    logic       oe;
    logic [2:0] drive;
    logic [3:0] func;
    logic [1:0] pull;
  } pad_cfg_t;

  // bit 8 down to bit 0
  typedef struct packed {
    logic       direct;
    logic [2:0] target;
    logic       stat_en;
    det_mode_e  mode;
    logic       pol_hi;
    logic       irq_en;
  } irq_cfg_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] hist_o
);

  logic [WIDTH-1:0] meta_q, sync_q, hist_q;
  logic [WIDTH-1:0] meta_d, sync_d, hist_d;

  always_comb begin
    meta_d = raw_i;
    sync_d = meta_q;
    hist_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign sync_o = sync_q;
  assign hist_o = hist_q;

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pad_i,
  input  logic              wr_data_i,
  input  logic              wr_icfg_i,
  input  logic              clr_i,
  input  logic [PCFG_W-1:0] wdata_i,
  input  logic              sync_i,
  input  logic              hist_i,
  output pad_cfg_t          pad_cfg_o,
  output logic              out_val_o,
  output irq_cfg_t          irq_cfg_o,
  output logic              status_o,
  output logic              irq_o,
  output logic              pad_oe_o,
  output logic              pad_out_o
);

  pad_cfg_t pad_q, pad_d;
  irq_cfg_t icfg_q, icfg_d;
  logic     out_q, out_d;
  logic     status_q, status_d;
  logic     pend_q, pend_d;
  logic     trig;
  logic     hit;

  always_comb begin
    unique case (icfg_q.mode)
      DET_LEVEL: trig = (sync_i == icfg_q.pol_hi);
      DET_RISE:  trig = sync_i & ~hist_i;
      DET_FALL:  trig = ~sync_i & hist_i;
      default:   trig = sync_i ^ hist_i;
    endcase
  end

  assign hit = trig & ~icfg_q.direct;

  always_comb begin
    pad_d    = pad_q;
    out_d    = out_q;
    icfg_d   = icfg_q;
    status_d = status_q;
    pend_d   = pend_q;
    if (wr_pad_i)  pad_d  = pad_cfg_t'(wdata_i);
    if (wr_data_i) out_d  = wdata_i[1];
    if (wr_icfg_i) icfg_d = irq_cfg_t'(wdata_i[ICFG_W-1:0]);
    if (hit && icfg_q.stat_en) status_d = 1'b1;
    else if (clr_i)            status_d = 1'b0;
    if (hit)        pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q    <= '0;
      out_q    <= 1'b0;
      icfg_q   <= '0;
      status_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      pad_q    <= pad_d;
      out_q    <= out_d;
      icfg_q   <= icfg_d;
      status_q <= status_d;
      pend_q   <= pend_d;
    end
  end

  assign irq_o = pend_q & icfg_q.irq_en & ~icfg_q.direct &
                 (icfg_q.target == TGT_APPS);
  assign pad_oe_o  = pad_q.oe;
  assign pad_out_o = pad_q.oe & out_q;
  assign pad_cfg_o = pad_q;
  assign out_val_o = out_q;
  assign irq_cfg_o = icfg_q;
  assign status_o  = status_q;

  AST_DIRECT_BLOCKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (icfg_q.direct && !status_q) |=> !status_q); // R9

  AST_STATEN_GATES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!icfg_q.stat_en && !status_q) |=> !status_q); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> (!status_q && !irq_o)); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && status_q) |=> status_q); // R10

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS = 4,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W   = IDX_W + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);

  logic                rst_meta_q, rst_sync_q;
  logic                arst_n;
  logic [NUM_PINS-1:0] sync_lvl, hist_lvl, pin_irq, pin_stat, pin_outv;
  pad_cfg_t            pad_cfg [NUM_PINS];
  irq_cfg_t            irq_cfg [NUM_PINS];
  logic [IDX_W-1:0]    sel_idx;
  reg_sel_e            sel_reg;
  logic                wr_en, rd_en, wr_zero;
  logic [WORD_W-1:0]   rd_mux, rdata_q, rdata_d;
  logic                unused_addr;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign arst_n = rst_sync_q;

  assign sel_idx     = bus_addr[ADDR_W-1:4];
  assign sel_reg     = reg_sel_e'(bus_addr[3:2]);
  assign wr_en       = bus_sel & bus_wr;
  assign rd_en       = bus_sel & ~bus_wr;
  assign wr_zero     = (bus_wdata == '0);
  assign unused_addr = ^{bus_addr[1:0], bus_wdata[WORD_W-1:PCFG_W]};

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (arst_n),
    .raw_i  (pin_in),
    .sync_o (sync_lvl),
    .hist_o (hist_lvl)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit_me;
    assign hit_me = wr_en && (sel_idx == IDX_W'(p));

    gpio_pin_slice u_slice (
      .clk       (clk),
      .rst_n     (arst_n),
      .wr_pad_i  (hit_me && sel_reg == RSEL_PAD),
      .wr_data_i (hit_me && sel_reg == RSEL_DATA),
      .wr_icfg_i (hit_me && sel_reg == RSEL_ICFG),
      .clr_i     (hit_me && sel_reg == RSEL_STAT && wr_zero),
      .wdata_i   (bus_wdata[PCFG_W-1:0]),
      .sync_i    (sync_lvl[p]),
      .hist_i    (hist_lvl[p]),
      .pad_cfg_o (pad_cfg[p]),
      .out_val_o (pin_outv[p]),
      .irq_cfg_o (irq_cfg[p]),
      .status_o  (pin_stat[p]),
      .irq_o     (pin_irq[p]),
      .pad_oe_o  (pin_oe[p]),
      .pad_out_o (pin_out[p])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (sel_idx == IDX_W'(p)) begin
        unique case (sel_reg)
          RSEL_PAD:  rd_mux = WORD_W'(pad_cfg[p]);
          RSEL_DATA: rd_mux = WORD_W'({pin_outv[p], sync_lvl[p]});
          RSEL_ICFG: rd_mux = WORD_W'(irq_cfg[p]);
          default:   rd_mux = WORD_W'(pin_stat[p]);
        endcase
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = |pin_irq;

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    !rd_en |=> $stable(bus_rdata)); // R11

  AST_NO_DRIVE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pin_out) |-> pin_oe); // R2

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;

  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // mode[5:4] pol[3] start[2] final[1] expected[0]
  localparam logic [5:0] VEC [0:10] = '{
    6'b00_1000, 6'b00_1011, 6'b00_0110, 6'b00_0101,
    6'b01_1011, 6'b01_1100, 6'b10_1101, 6'b10_1010,
    6'b11_1011, 6'b11_1101, 6'b11_1000
  };

  always #2 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP)) u_gpio_irq_bank (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq_out (irq_out)
  );

  function automatic logic [5:0] adr(int p, int r);
    return 6'(p * 16 + r * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int p, int r, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr(p, r); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(int p, int r, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = adr(p, r);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // block triggers, park the pin, clear its flags
  task automatic prep(int p, logic lvl);
    wr(p, 2, 32'h100);
    pin_in[p] = lvl;
    settle();
    wr(p, 3, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R12 reset state
    chk("R12 pin_oe", 32'(pin_oe), 32'h0);
    chk("R12 irq_out", 32'(irq_out), 32'h0);
    rd(0, 0, d); chk("R12 pad cfg", d, 32'h0);
    rd(1, 2, d); chk("R12 irq cfg", d, 32'h0);
    rd(3, 3, d); chk("R12 status", d, 32'h0);

    // R1 readback masks, R2 output drive
    wr(2, 0, 32'hFFFF_FFFF);
    rd(2, 0, d); chk("R1 pad cfg readback", d, 32'h3FF);
    wr(2, 2, 32'hFFFF_FFFF);
    rd(2, 2, d); chk("R1 irq cfg readback", d, 32'h1FF);
    chk("R2 oe set", 32'(pin_oe[2]), 32'h1);
    chk("R2 out low", 32'(pin_out[2]), 32'h0);
    wr(2, 1, 32'h2);
    chk("R2 out driven", 32'(pin_out[2]), 32'h1);
    wr(2, 0, 32'h0);
    chk("R2 out gated by oe", 32'(pin_out[2]), 32'h0);
    chk("R2 oe cleared", 32'(pin_oe[2]), 32'h0);
    wr(2, 2, 32'h0);

    // R3 input sampling, R11 read data holds
    pin_in[1] = 1'b1; settle();
    rd(1, 1, d); chk("R3 input high", d, 32'h1);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", bus_rdata, 32'h1);
    pin_in[1] = 1'b0; settle();
    rd(1, 1, d); chk("R3 input low", d, 32'h0);
    rd(2, 1, d); chk("R3 output readback", d, 32'h2);

    // R4 R5 table of detect modes
    for (int v = 0; v < 11; v++) begin
      logic [5:0] e;
      e = VEC[v];
      prep(0, e[2]);
      wr(0, 2, 32'(1 | (e[3] << 1) | (e[5:4] << 2) | (1 << 4) | (4 << 5)));
      repeat (2) @(negedge clk);
      pin_in[0] = e[1];
      settle();
      rd(0, 3, d);
      chk($sformatf("R4 R5 vector %0d status", v), d, 32'(e[0]));
      chk($sformatf("R4 R5 vector %0d irq", v), 32'(irq_out), 32'(e[0]));
    end

    // R6 status disabled, interrupt still raised
    prep(0, 1'b0);
    wr(0, 2, 32'd133);
    pin_in[0] = 1'b1; settle();
    rd(0, 3, d); chk("R6 status stays 0", d, 32'h0);
    chk("R6 irq raised", 32'(irq_out), 32'h1);
    wr(0, 3, 32'h0);
    chk("R10 clear drops irq", 32'(irq_out), 32'h0);

    // R7 interrupt disabled, status set; late enable
    prep(0, 1'b0);
    wr(0, 2, 32'd148);
    pin_in[0] = 1'b1; settle();
    rd(0, 3, d); chk("R7 status set", d, 32'h1);
    chk("R7 irq masked", 32'(irq_out), 32'h0);
    wr(0, 3, 32'h5);
    rd(0, 3, d); chk("R10 nonzero write ignored", d, 32'h1);
    wr(0, 2, 32'd149);
    chk("R7 late enable raises irq", 32'(irq_out), 32'h1);
    wr(0, 3, 32'h0);
    rd(0, 3, d); chk("R10 zero write clears", d, 32'h0);
    chk("R10 irq cleared", 32'(irq_out), 32'h0);

    // R8 no-target code
    prep(0, 1'b0);
    wr(0, 2, 32'd245);
    pin_in[0] = 1'b1; settle();
    rd(0, 3, d); chk("R8 status with target 7", d, 32'h1);
    chk("R8 irq blocked", 32'(irq_out), 32'h0);

    // R9 direct connect
    prep(0, 1'b0);
    wr(0, 2, 32'd405);
    pin_in[0] = 1'b1; settle();
    rd(0, 3, d); chk("R9 status untouched", d, 32'h0);
    chk("R9 irq excluded", 32'(irq_out), 32'h0);

    // R10 trigger wins over clear (level held)
    prep(0, 1'b0);
    wr(0, 2, 32'd147);
    pin_in[0] = 1'b1; settle();
    wr(0, 3, 32'h0);
    rd(0, 3, d); chk("R10 level re-sets status", d, 32'h1);

    // R13 independence
    prep(0, 1'b0);
    prep(3, 1'b0);
    wr(0, 2, 32'd149);
    wr(3, 2, 32'd149);
    pin_in[3] = 1'b1; settle();
    rd(3, 3, d); chk("R13 pin 3 status", d, 32'h1);
    rd(0, 3, d); chk("R13 pin 0 untouched", d, 32'h0);
    chk("R13 irq from pin 3", 32'(irq_out), 32'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule